// File: doc/BRIEF.md
# Compare-and-Flag Unit

This block sits beside the integer datapath of a small in-order core. It evaluates the two compare instructions and keeps the single condition flag that the conditional jumps read. The decoder gives it the instruction's 6-bit opcode, the low three bits of the destination-register field and an issue strobe. The register file gives it the `rs` and `rb` operands, and the decoder also gives it the 16-bit immediate. The destination field of a compare names no register. The block reads it as a condition selector.

When a compare instruction is issued, the block compares `rs` with the second operand under the selected condition. The flag register takes the result on that clock edge. The second operand is the sign-extended immediate for the immediate form and `rb` for the register form. At every other time the flag holds its value. Branch logic reads the flag as a plain registered output. A jump issued in the same cycle as a compare therefore sees the flag from before that compare.

Top module: `cond_flag_unit`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the flag is 0 after that edge, whatever its earlier value.
- R2: Opcode 0x2F (compare with immediate) compares `rs_val` with `imm` sign-extended to the data width.
- R3: Opcode 0x39 (compare registers) compares `rs_val` with `rb_val`.
- R4: Selector code 0 loads 1 exactly when the operands are equal, and code 1 loads 1 exactly when they differ.
- R5: Selector codes 2 (greater), 3 (greater or equal), 4 (less) and 5 (less or equal) order `rs_val` against the second operand as signed two's-complement numbers.
- R6: Selector codes 6 and 7 always load 0 into the flag.
- R7: The flag keeps its value across any edge where `issue_en` is low, and across any edge where the opcode is neither 0x2F nor 0x39.
- R8: A compare changes `flag` only after the edge that issues it. During the issuing cycle `flag` still shows the previous value.
- R9: An immediate with bit 15 set takes part as a negative number: 0x8000 equals -32768 and 0xFFFF equals -1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; everything updates on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| issue_en | input | 1 | An instruction is issued in this cycle |
| opcode | input | 6 | Primary opcode of the issued instruction |
| cond_sel | input | 3 | Low three bits of the destination-register field, read as the condition code |
| rs_val | input | 32 | First operand (rs register value) |
| rb_val | input | 32 | Second operand for the register form |
| imm | input | 16 | Immediate for the immediate form |
| flag | output | 1 | Registered condition flag for the conditional jumps |

## Verification
A conditional jump reads `flag` while the decoder may issue a new compare in the same cycle. The read and the update therefore meet on one edge. The bench loads a known flag value and then drives a compare that will flip it. It samples `flag` after the inputs settle and before the edge, and expects the old value. It samples again just after the edge and expects the new one. A second collision pairs a compare-like opcode with the issue strobe low, or the strobe high with a different opcode, and checks that the flag is left alone in both cases.

// File: rtl/cond_flag_pkg.sv
// Package: shared constants and the condition-code type for the compare unit.
// Assumes the opcode values are fixed by the instruction decoder.
package cond_flag_pkg;

    localparam int OPCODE_W = 6;
    localparam int SEL_W    = 3;

    localparam logic [OPCODE_W-1:0] OP_CMP_IMM = 6'h2F;
    localparam logic [OPCODE_W-1:0] OP_CMP_REG = 6'h39;

    typedef enum logic [SEL_W-1:0] {
        COND_EQ  = 3'd0,
        COND_NE  = 3'd1,
        COND_GT  = 3'd2,
        COND_GE  = 3'd3,
        COND_LT  = 3'd4,
        COND_LE  = 3'd5,
        COND_NO6 = 3'd6,
        COND_NO7 = 3'd7
    } cond_e;

endpackage

// File: rtl/cmp_operand_sel.sv
// Module: selects the second compare operand.
// For the immediate form it sign-extends the immediate to the data width.
// For the register form it passes rb through unchanged.
// Assumes IMM_W is at least 1.
module cmp_operand_sel #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic              use_imm,
    input  logic [DATA_W-1:0] rb_val,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] op_b
);
    localparam int EXT_W = (DATA_W > IMM_W) ? (DATA_W - IMM_W) : 0;

    logic [DATA_W-1:0] imm_ext;

    // Sign-extend or truncate the immediate; the variant depends on the widths.
    generate
        if (EXT_W > 0) begin : g_extend
            assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};
        end else begin : g_trunc
            assign imm_ext = imm[DATA_W-1:0];
        end
    endgenerate

    // Choose between the immediate and the register operand.
    always_comb begin
        op_b = use_imm ? imm_ext : rb_val;
    end
endmodule

// File: rtl/cmp_magnitude.sv
// Module: signed magnitude comparator.
// It gives separate less, equal and greater outputs for two's-complement operands.
// Assumes both operands are signed values of the same width.
module cmp_magnitude #(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] op_a,
    input  logic [DATA_W-1:0] op_b,
    output logic              a_lt,
    output logic              a_eq,
    output logic              a_gt
);
    // Produce the three exclusive relations from separate comparisons.
    always_comb begin
        a_eq = (op_a == op_b);
        a_lt = ($signed(op_a) < $signed(op_b));
        a_gt = ($signed(op_a) > $signed(op_b));
    end
endmodule

// File: rtl/cmp_flag_reg.sv
// Module: condition-code selection and the registered flag.
// It maps the 3-bit code onto the comparator relations and loads the flag when `load` is high.
// Assumes exactly one of lt/eq/gt is high whenever `load` is high.
module cmp_flag_reg
    import cond_flag_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [SEL_W-1:0] sel,
    input  logic             a_lt,
    input  logic             a_eq,
    input  logic             a_gt,
    output logic             flag_q
);
    cond_e cond;
    logic  cond_true;

    // Turn the selector code into a condition result.
    always_comb begin
        cond = cond_e'(sel);
        unique case (cond)
            COND_EQ:  cond_true = a_eq;
            COND_NE:  cond_true = ~a_eq;
            COND_GT:  cond_true = a_gt;
            COND_GE:  cond_true = a_gt | a_eq;
            COND_LT:  cond_true = a_lt;
            COND_LE:  cond_true = a_lt | a_eq;
            default:  cond_true = 1'b0;
        endcase
    end

    // Flag register: synchronous reset, loaded only on an issued compare.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (load) begin
            flag_q <= cond_true;
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk) !rst_n |=> !flag_q);

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(flag_q));

    // R6
    false_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && sel[2] && sel[1]) |=> !flag_q);

    // R5
    relation_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> ($countones({a_lt, a_eq, a_gt}) == 1));
endmodule

// File: rtl/cond_flag_unit.sv
// Module: compare-and-flag unit (top).
// It decodes the two compare opcodes, picks the second operand, compares the
// operands as signed numbers and registers the selected condition as the flag.
// Assumes the decoder gives the low bits of the rt field on cond_sel.
module cond_flag_unit
    import cond_flag_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                issue_en,
    input  logic [OPCODE_W-1:0] opcode,
    input  logic [SEL_W-1:0]    cond_sel,
    input  logic [DATA_W-1:0]   rs_val,
    input  logic [DATA_W-1:0]   rb_val,
    input  logic [IMM_W-1:0]    imm,
    output logic                flag
);
    logic              is_cmp_imm;
    logic              is_cmp_reg;
    logic              load;
    logic [DATA_W-1:0] op_b;
    logic              a_lt, a_eq, a_gt;

    // Decode the compare opcodes and qualify them with the issue strobe.
    always_comb begin
        is_cmp_imm = (opcode == OP_CMP_IMM);
        is_cmp_reg = (opcode == OP_CMP_REG);
        load       = issue_en & (is_cmp_imm | is_cmp_reg);
    end

    cmp_operand_sel #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_opsel (
        .use_imm (is_cmp_imm),
        .rb_val  (rb_val),
        .imm     (imm),
        .op_b    (op_b)
    );

    cmp_magnitude #(.DATA_W(DATA_W)) u_mag (
        .op_a (rs_val),
        .op_b (op_b),
        .a_lt (a_lt),
        .a_eq (a_eq),
        .a_gt (a_gt)
    );

    cmp_flag_reg u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (load),
        .sel    (cond_sel),
        .a_lt   (a_lt),
        .a_eq   (a_eq),
        .a_gt   (a_gt),
        .flag_q (flag)
    );

    // R7
    other_opcode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_en && !is_cmp_imm && !is_cmp_reg) |=> $stable(flag));
endmodule

// File: tb/test_cond_flag_unit.sv
// Directed bench for cond_flag_unit; each task checks its own results.
module test_cond_flag_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue_en = 1'b0;
    logic [5:0]  opcode = 6'h00;
    logic [2:0]  cond_sel = 3'd0;
    logic [31:0] rs_val = 32'd0;
    logic [31:0] rb_val = 32'd0;
    logic [15:0] imm = 16'd0;
    logic        flag;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [5:0] CMPI = 6'h2F;
    localparam logic [5:0] CMPR = 6'h39;

    always #2 clk = ~clk;

    cond_flag_unit i_cond_flag_unit (
        .clk(clk), .rst_n(rst_n), .issue_en(issue_en), .opcode(opcode),
        .cond_sel(cond_sel), .rs_val(rs_val), .rb_val(rb_val), .imm(imm),
        .flag(flag)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: flag=%b expected %b", tag, act, exp);
        end
    endtask

    // Issue one instruction, then sample the flag just after the edge.
    task automatic step(input logic en, input logic [5:0] op, input logic [2:0] sel,
                        input logic [31:0] a, input logic [31:0] b, input logic [15:0] im);
        @(negedge clk);
        issue_en = en; opcode = op; cond_sel = sel; rs_val = a; rb_val = b; imm = im;
        @(posedge clk);
        #1;
        issue_en = 1'b0;
    endtask

    task automatic t_reset;
        step(1'b1, CMPR, 3'd0, 32'd7, 32'd7, 16'd0);
        chk("R4 setup", flag, 1'b1);
        @(negedge clk); rst_n = 1'b0;
        @(posedge clk); #1;
        chk("R1", flag, 1'b0);
        @(negedge clk); rst_n = 1'b1;
    endtask

    task automatic t_equality;
        step(1'b1, CMPR, 3'd0, 32'd5, 32'd5, 16'd0);  chk("R4/R3 eq same", flag, 1'b1);
        step(1'b1, CMPR, 3'd1, 32'd5, 32'd5, 16'd0);  chk("R4/R3 ne same", flag, 1'b0);
        step(1'b1, CMPR, 3'd1, 32'd5, 32'd6, 16'd0);  chk("R4/R3 ne diff", flag, 1'b1);
        step(1'b1, CMPR, 3'd0, 32'd5, 32'd6, 16'd0);  chk("R4/R3 eq diff", flag, 1'b0);
    endtask

    task automatic t_signed_reg;
        step(1'b1, CMPR, 3'd2, 32'hFFFF_FFFF, 32'd1, 16'd0); chk("R5 gt neg", flag, 1'b0);
        step(1'b1, CMPR, 3'd4, 32'hFFFF_FFFF, 32'd1, 16'd0); chk("R5 lt neg", flag, 1'b1);
        step(1'b1, CMPR, 3'd3, 32'd9, 32'd9, 16'd0);         chk("R5 ge eq", flag, 1'b1);
        step(1'b1, CMPR, 3'd2, 32'd9, 32'd9, 16'd0);         chk("R5 gt eq", flag, 1'b0);
        step(1'b1, CMPR, 3'd5, 32'd9, 32'd9, 16'd0);         chk("R5 le eq", flag, 1'b1);
        step(1'b1, CMPR, 3'd4, 32'd9, 32'd9, 16'd0);         chk("R5 lt eq", flag, 1'b0);
        step(1'b1, CMPR, 3'd3, 32'h8000_0000, 32'h7FFF_FFFF, 16'd0); chk("R5 ge min", flag, 1'b0);
    endtask

    task automatic t_immediate;
        step(1'b1, CMPI, 3'd0, 32'hFFFF_8000, 32'd0, 16'h8000); chk("R9/R2 eq -32768", flag, 1'b1);
        step(1'b1, CMPI, 3'd0, 32'h0000_8000, 32'd0, 16'h8000); chk("R9/R2 eq +32768", flag, 1'b0);
        step(1'b1, CMPI, 3'd2, 32'd0, 32'd0, 16'hFFFF);         chk("R9/R2 gt -1", flag, 1'b1);
        step(1'b1, CMPI, 3'd0, 32'd1234, 32'd99, 16'd1234);     chk("R2 ignores rb", flag, 1'b1);
    endtask

    task automatic t_false_codes;
        step(1'b1, CMPR, 3'd0, 32'd3, 32'd3, 16'd0); chk("R6 setup", flag, 1'b1);
        step(1'b1, CMPR, 3'd6, 32'd3, 32'd3, 16'd0); chk("R6 code6", flag, 1'b0);
        step(1'b1, CMPR, 3'd0, 32'd3, 32'd3, 16'd0);
        step(1'b1, CMPI, 3'd7, 32'd8, 32'd0, 16'd1); chk("R6 code7", flag, 1'b0);
    endtask

    task automatic t_hold;
        step(1'b1, CMPR, 3'd0, 32'd1, 32'd1, 16'd0); chk("R7 setup", flag, 1'b1);
        step(1'b0, CMPI, 3'd1, 32'd1, 32'd1, 16'd1); chk("R7 issue low", flag, 1'b1);
        step(1'b1, 6'h38, 3'd1, 32'd1, 32'd1, 16'd1); chk("R7 other op", flag, 1'b1);
        step(1'b1, 6'h2E, 3'd6, 32'd1, 32'd2, 16'd0); chk("R7 near op", flag, 1'b1);
    endtask

    task automatic t_same_cycle;
        step(1'b1, CMPR, 3'd1, 32'd1, 32'd2, 16'd0); chk("R8 setup", flag, 1'b1);
        @(negedge clk);
        issue_en = 1'b1; opcode = CMPR; cond_sel = 3'd0; rs_val = 32'd1; rb_val = 32'd2;
        #1;
        chk("R8 before edge", flag, 1'b1);
        @(posedge clk); #1;
        issue_en = 1'b0;
        chk("R8 after edge", flag, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 initial", flag, 1'b0);
        t_reset();
        t_equality();
        t_signed_reg();
        t_immediate();
        t_false_codes();
        t_hold();
        t_same_cycle();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: flag=%b expected completion", flag);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule